// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface. It takes a freshly powered memory from the state after power-up to a state where it accepts normal traffic. After a start pulse it keeps the clock-enable pin low for a long settling interval. It then wakes the device and drives a fixed series of commands on the active-low command pins, with a timed run of NOP cycles after each command: precharge-all, extended register load, base register load with DLL reset, a second precharge-all, two auto-refreshes, and an optional load that clears the DLL-reset bit.

The settling time, precharge time, register-load time, refresh time and DLL lock interval are clock-cycle counts set as parameters. The base and extended register values come in as inputs. The block keeps only the drive-strength bit of the extended value and forces the DLL-enable and reserved bits to zero. Two flags report progress. `init_done` marks the end of the sequence. `read_ok` tells the controller that enough cycles have passed since the DLL reset for a READ to be legal. A new start pulse restarts everything from the clock-enable-low phase.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is high and afterwards, until the first start, `cke` is 0, the pins show DESELECT ({cs_n,ras_n,cas_n,we_n}=1111), and `init_done` and `read_ok` are 0. Whenever `cke` is 0, `cs_n` is 1.
- R2: If `start` is high in cycle s, `cke` first goes high in cycle s+T_PWR+2. In that first high cycle the pins show NOP (0111).
- R3: With CLEAR_DLL=1 the commands come in this order: PRECHARGE (0010, addr bit 10 = 1), LOAD MODE (0000) with ba=01, LOAD MODE with ba=00, PRECHARGE, AUTO REFRESH (0001), AUTO REFRESH, LOAD MODE with ba=00.
- R4: The first PRECHARGE comes one cycle after `cke` rises. After each command the next one comes T+1 cycles later. T is T_RP after a PRECHARGE, T_MRD after a LOAD MODE and T_RFC after an AUTO REFRESH.
- R5: From the start of the sequence until it ends, every cycle with `cke`=1 that carries no command shows NOP (0111), and every cycle with `cke`=0 shows DESELECT.
- R6: The extended load (ba=01) drives addr = `ext_mode` & 2. Bit 0 is 0, bit 1 is the drive-strength bit, and all other input bits are ignored.
- R7: The first base load drives `mode_val` with bit 8 set to 1 (DLL reset). The final base load drives `mode_val` with bit 8 cleared and all other bits unchanged.
- R8: `init_done` rises T+1 cycles after the last command, where T is the wait after that command. It then stays high while `cke` stays 1 and the pins show NOP, until the next start.
- R9: `read_ok` is never high while `init_done` is low. It rises exactly T_DLL cycles after the cycle in which the DLL-reset load is on the pins, provided `init_done` is high by then.
- R10: A `start` in cycle s, even in the middle of a run or after it ends, drives `cke`, `init_done` and `read_ok` to 0 and the pins to DESELECT in cycle s+2.
- R11: With CLEAR_DLL=0 the sequence ends after the second AUTO REFRESH (six commands), and `init_done` rises T_RFC+1 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts or restarts the sequence |
| mode_val | input | AW | Base mode-register operating value |
| ext_mode | input | AW | Extended register value; only bit 1 is used |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BAW | Bank address |
| addr | output | AW | Address lines |
| init_done | output | 1 | Sequence finished |
| read_ok | output | 1 | DLL lock interval elapsed, READ allowed |

## Verification
All outputs are registered one stage behind the state machine. As a result, the first pin change after a start comes in cycle s+2, and every later interval is measured pin to pin. The bench samples on falling edges and records the cycle number of every command, the cycle in which `cke` rises, and the cycles in which each flag rises. It then compares the exact differences: T_PWR+2 from start to wake-up, T+1 between commands, T+1 from the last command to `init_done`, and T_DLL from the DLL-reset load to `read_ok`. Restart checks sample exactly two cycles after the start cycle.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_PRE,
    CMD_REF,
    CMD_LMR
  } cmd_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_PWR,
    ST_WAKE,
    ST_PRE1,
    ST_RP1,
    ST_EMR,
    ST_MRD1,
    ST_MRS,
    ST_MRD2,
    ST_PRE2,
    ST_RP2,
    ST_REF1,
    ST_RFC1,
    ST_REF2,
    ST_RFC2,
    ST_MRC,
    ST_MRD3,
    ST_DONE
  } step_e;

endpackage

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          last
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == TW'(1));

  // the count only moves down by one, or is reloaded
  p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr_dll_guard.sv
module ddr_dll_guard #(
  parameter int T_DLL = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic arm,
  output logic expired
);
  localparam int GW = (T_DLL < 2) ? 1 : $clog2(T_DLL);

  logic [GW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (arm) begin
      cnt_q   <= GW'(T_DLL - 1);
      armed_q <= 1'b1;
    end else if (armed_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = armed_q && (cnt_q == '0);

  // R9: an arm always restarts the full interval
  p_arm_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (arm && !clear) |=> !expired || (T_DLL == 1));

endmodule

// File: rtl/ddr_cmd_drive.sv
module ddr_cmd_drive
  import ddr_init_pkg::*;
#(
  parameter int AW  = 13,
  parameter int BAW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cke_i,
  input  cmd_e           cmd_i,
  input  logic [BAW-1:0] ba_i,
  input  logic [AW-1:0]  addr_i,
  output logic           cke_o,
  output logic           cs_n_o,
  output logic           ras_n_o,
  output logic           cas_n_o,
  output logic           we_n_o,
  output logic [BAW-1:0] ba_o,
  output logic [AW-1:0]  addr_o
);
  logic [3:0] pins_c;
  logic       keep_addr;

  always_comb begin
    keep_addr = 1'b0;
    unique case (cmd_i)
      CMD_NOP:  pins_c = 4'b0111;
      CMD_PRE:  begin pins_c = 4'b0010; keep_addr = 1'b1; end
      CMD_REF:  pins_c = 4'b0001;
      CMD_LMR:  begin pins_c = 4'b0000; keep_addr = 1'b1; end
      default:  pins_c = 4'b1111;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_o   <= 1'b0;
      cs_n_o  <= 1'b1;
      ras_n_o <= 1'b1;
      cas_n_o <= 1'b1;
      we_n_o  <= 1'b1;
      ba_o    <= '0;
      addr_o  <= '0;
    end else begin
      cke_o   <= cke_i;
      cs_n_o  <= pins_c[3];
      ras_n_o <= pins_c[2];
      cas_n_o <= pins_c[1];
      we_n_o  <= pins_c[0];
      ba_o    <= keep_addr ? ba_i : '0;
      addr_o  <= keep_addr ? addr_i : '0;
    end
  end

  // R1: no command reaches the memory while its clock is disabled
  p_cke_low_deselect_r1: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> cs_n_o);

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_init_pkg::*;
#(
  parameter int AW        = 13,
  parameter int BAW       = 2,
  parameter int T_PWR     = 10000,
  parameter int T_RP      = 3,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 14,
  parameter int T_DLL     = 200,
  parameter bit CLEAR_DLL = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  mode_val,
  input  logic [AW-1:0]  ext_mode,
  output logic           cke,
  output logic           cs_n,
  output logic           ras_n,
  output logic           cas_n,
  output logic           we_n,
  output logic [BAW-1:0] ba,
  output logic [AW-1:0]  addr,
  output logic           init_done,
  output logic           read_ok
);
  localparam int DLL_BIT  = 8;
  localparam int AP_BIT   = 10;
  localparam int DRV_BIT  = 1;
  localparam int M_A      = (T_PWR > T_RP)  ? T_PWR : T_RP;
  localparam int M_B      = (T_MRD > T_RFC) ? T_MRD : T_RFC;
  localparam int T_MAX    = (M_A > M_B) ? M_A : M_B;
  localparam int TW       = $clog2(T_MAX + 1);
  localparam logic [AW-1:0]  DLL_MASK = AW'(1) << DLL_BIT;
  localparam logic [AW-1:0]  AP_MASK  = AW'(1) << AP_BIT;
  localparam logic [AW-1:0]  EXT_KEEP = AW'(1) << DRV_BIT;
  localparam logic [BAW-1:0] BA_BASE  = BAW'(0);
  localparam logic [BAW-1:0] BA_EXT   = BAW'(1);

  step_e          st_q, st_d;
  logic           t_load, t_last;
  logic [TW-1:0]  t_len;
  logic           cke_c;
  cmd_e           cmd_c;
  logic [BAW-1:0] ba_c;
  logic [AW-1:0]  addr_c;
  logic           dll_expired;
  logic           done_q, read_q;
  step_e          after_rfc;

  // variant choice: whether the sequence ends with the DLL-reset clear
  generate
    if (CLEAR_DLL) begin : g_clear
      assign after_rfc = ST_MRC;
    end else begin : g_noclear
      assign after_rfc = ST_DONE;
    end
  endgenerate

  ddr_wait_timer #(.TW(TW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (t_load),
    .len  (t_len),
    .last (t_last)
  );

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_len  = '0;
    if (start) begin
      st_d   = ST_PWR;
      t_load = 1'b1;
      t_len  = TW'(T_PWR);
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_PWR:  if (t_last) st_d = ST_WAKE;
        ST_WAKE: st_d = ST_PRE1;
        ST_PRE1: begin st_d = ST_RP1;  t_load = 1'b1; t_len = TW'(T_RP);  end
        ST_RP1:  if (t_last) st_d = ST_EMR;
        ST_EMR:  begin st_d = ST_MRD1; t_load = 1'b1; t_len = TW'(T_MRD); end
        ST_MRD1: if (t_last) st_d = ST_MRS;
        ST_MRS:  begin st_d = ST_MRD2; t_load = 1'b1; t_len = TW'(T_MRD); end
        ST_MRD2: if (t_last) st_d = ST_PRE2;
        ST_PRE2: begin st_d = ST_RP2;  t_load = 1'b1; t_len = TW'(T_RP);  end
        ST_RP2:  if (t_last) st_d = ST_REF1;
        ST_REF1: begin st_d = ST_RFC1; t_load = 1'b1; t_len = TW'(T_RFC); end
        ST_RFC1: if (t_last) st_d = ST_REF2;
        ST_REF2: begin st_d = ST_RFC2; t_load = 1'b1; t_len = TW'(T_RFC); end
        ST_RFC2: if (t_last) st_d = after_rfc;
        ST_MRC:  begin st_d = ST_MRD3; t_load = 1'b1; t_len = TW'(T_MRD); end
        ST_MRD3: if (t_last) st_d = ST_DONE;
        default: st_d = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  always_comb begin
    cke_c  = 1'b1;
    cmd_c  = CMD_NOP;
    ba_c   = '0;
    addr_c = '0;
    unique case (st_q)
      ST_IDLE, ST_PWR: begin
        cke_c = 1'b0;
        cmd_c = CMD_DESEL;
      end
      ST_PRE1, ST_PRE2: begin
        cmd_c  = CMD_PRE;
        addr_c = AP_MASK;
      end
      ST_EMR: begin
        cmd_c  = CMD_LMR;
        ba_c   = BA_EXT;
        addr_c = ext_mode & EXT_KEEP;
      end
      ST_MRS: begin
        cmd_c  = CMD_LMR;
        ba_c   = BA_BASE;
        addr_c = mode_val | DLL_MASK;
      end
      ST_MRC: begin
        cmd_c  = CMD_LMR;
        ba_c   = BA_BASE;
        addr_c = mode_val & ~DLL_MASK;
      end
      ST_REF1, ST_REF2: cmd_c = CMD_REF;
      default: cmd_c = CMD_NOP;
    endcase
  end

  ddr_cmd_drive #(.AW(AW), .BAW(BAW)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .cke_i   (cke_c),
    .cmd_i   (cmd_c),
    .ba_i    (ba_c),
    .addr_i  (addr_c),
    .cke_o   (cke),
    .cs_n_o  (cs_n),
    .ras_n_o (ras_n),
    .cas_n_o (cas_n),
    .we_n_o  (we_n),
    .ba_o    (ba),
    .addr_o  (addr)
  );

  ddr_dll_guard #(.T_DLL(T_DLL)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .arm     (st_q == ST_MRS),
    .expired (dll_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      read_q <= 1'b0;
    end else begin
      done_q <= (st_q == ST_DONE);
      read_q <= (st_q == ST_DONE) && dll_expired;
    end
  end

  assign init_done = done_q;
  assign read_ok   = read_q;

  // ---------------- checks next to the sequencing logic ----------------
  localparam int SW = $clog2(T_DLL + 2);
  logic [SW-1:0] since_mr_q;
  logic          seen_mr_q;
  logic          pins_nop, pins_lmr, in_wait;

  assign pins_nop = !cs_n && ras_n && cas_n && we_n;
  assign pins_lmr = !cs_n && !ras_n && !cas_n && !we_n;
  assign in_wait  = (st_q == ST_RP1) || (st_q == ST_RP2) || (st_q == ST_MRD1) ||
                    (st_q == ST_MRD2) || (st_q == ST_MRD3) || (st_q == ST_RFC1) ||
                    (st_q == ST_RFC2);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_mr_q <= '0;
      seen_mr_q  <= 1'b0;
    end else if (pins_lmr && ba == BA_BASE && addr[DLL_BIT]) begin
      since_mr_q <= SW'(1);
      seen_mr_q  <= 1'b1;
    end else if (since_mr_q != {SW{1'b1}}) begin
      since_mr_q <= since_mr_q + 1'b1;
    end
  end

  // R5: a timed wait puts only NOP on the pins
  p_wait_nop_r5: assert property (@(posedge clk) disable iff (rst)
    in_wait |=> (pins_nop && cke));

  // R6: only the drive-strength bit survives in the extended load
  p_ext_mask_r6: assert property (@(posedge clk) disable iff (rst)
    (pins_lmr && ba == BA_EXT) |-> ((addr & ~EXT_KEEP) == '0));

  // R9: read permission only after completion
  p_read_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
    read_ok |-> init_done);

  // R9: read permission never earlier than the lock interval
  p_read_gap_r9: assert property (@(posedge clk) disable iff (rst)
    read_ok |-> (seen_mr_q && since_mr_q >= SW'(T_DLL)));

  // R8: completion holds until a new start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (init_done && !start && !$past(start)) |=> init_done);

  // R10: a start forces the clock-enable-low phase two cycles later
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    start |-> ##2 (!cke && !init_done && !read_ok));

endmodule

// File: tb/sim_ddr_pwrup_seq.sv
module sim_ddr_pwrup_seq;
  localparam int AW    = 13;
  localparam int BAW   = 2;
  localparam int T_PWR = 20;
  localparam int T_RP  = 3;
  localparam int T_MRD = 2;
  localparam int T_RFC = 7;
  localparam int T_DLL = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] mode_val = '0;
  logic [AW-1:0] ext_mode = '0;

  logic c0, s0, r0, a0, w0, d0, k0;
  logic [BAW-1:0] b0;
  logic [AW-1:0]  x0;
  logic c1, s1, r1, a1, w1, d1, k1;
  logic [BAW-1:0] b1;
  logic [AW-1:0]  x1;

  always #10 clk = ~clk;

  ddr_pwrup_seq #(.AW(AW), .BAW(BAW), .T_PWR(T_PWR), .T_RP(T_RP), .T_MRD(T_MRD),
                  .T_RFC(T_RFC), .T_DLL(T_DLL), .CLEAR_DLL(1'b1)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode_val(mode_val), .ext_mode(ext_mode),
    .cke(c0), .cs_n(s0), .ras_n(r0), .cas_n(a0), .we_n(w0), .ba(b0), .addr(x0),
    .init_done(d0), .read_ok(k0));

  ddr_pwrup_seq #(.AW(AW), .BAW(BAW), .T_PWR(T_PWR), .T_RP(T_RP), .T_MRD(T_MRD),
                  .T_RFC(T_RFC), .T_DLL(T_DLL), .CLEAR_DLL(1'b0)) u1 (
    .clk(clk), .rst(rst), .start(start), .mode_val(mode_val), .ext_mode(ext_mode),
    .cke(c1), .cs_n(s1), .ras_n(r1), .cas_n(a1), .we_n(w1), .ba(b1), .addr(x1),
    .init_done(d1), .read_ok(k1));

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int s_cyc;

  int             ln [2];
  int             lc [2][16];
  logic [3:0]     lcode [2][16];
  logic [BAW-1:0] lba [2][16];
  logic [AW-1:0]  laddr [2][16];
  int             fcke [2];
  logic [3:0]     wcode [2];
  int             dcyc [2];
  int             rcyc [2];
  int             viol [2];
  logic           pcke [2];
  logic           pdone [2];
  logic           pread [2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clear_logs();
    for (int i = 0; i < 2; i++) begin
      ln[i] = 0; fcke[i] = -1; dcyc[i] = -1; rcyc[i] = -1; viol[i] = 0;
    end
  endtask

  task automatic observe(input int i, input logic ck, input logic [3:0] code,
                         input logic [BAW-1:0] b, input logic [AW-1:0] a,
                         input logic dn, input logic rd);
    if (ck && !pcke[i]) begin fcke[i] = cyc; wcode[i] = code; end
    if (ck) begin
      if (code != 4'b0111) begin
        if (!code[3]) begin
          if (ln[i] < 16) begin
            lc[i][ln[i]] = cyc; lcode[i][ln[i]] = code;
            lba[i][ln[i]] = b;  laddr[i][ln[i]] = a;
            ln[i]++;
          end
        end else viol[i]++;
      end
    end else if (code != 4'b1111) viol[i]++;
    if (dn && !pdone[i]) dcyc[i] = cyc;
    if (rd && !pread[i]) rcyc[i] = cyc;
    if (rd && !dn) viol[i]++;
    pcke[i] = ck; pdone[i] = dn; pread[i] = rd;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      observe(0, c0, {s0, r0, a0, w0}, b0, x0, d0, k0);
      observe(1, c1, {s1, r1, a1, w1}, b1, x1, d1, k1);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; s_cyc = cyc;
    @(negedge clk); start = 1'b0;
    @(posedge clk); #1 clear_logs();
  endtask

  task automatic wait_finish();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (rcyc[0] >= 0 && dcyc[1] >= 0) break;
    end
  endtask

  // R1: state after reset and before any start
  task automatic t_reset();
    @(negedge clk);
    check(c0 == 1'b0 && c1 == 1'b0, "R1 cke low", int'(c0), 0);
    check({s0, r0, a0, w0} == 4'b1111, "R1 deselect", int'({s0, r0, a0, w0}), 15);
    check(!d0 && !k0 && !d1 && !k1, "R1 flags low", int'({d0, k0, d1, k1}), 0);
    repeat (10) @(negedge clk);
    check(c0 == 1'b0 && s0 == 1'b1 && !d0, "R1 idle without start", int'(c0), 0);
  endtask

  task automatic t_full(input logic [AW-1:0] mv, input logic [AW-1:0] ev);
    int mr_cyc;
    @(negedge clk); mode_val = mv; ext_mode = ev;
    pulse_start();
    wait_finish();
    // R2: wake-up time and first cycle content
    check(fcke[0] - s_cyc == T_PWR + 2, "R2 cke rise", fcke[0] - s_cyc, T_PWR + 2);
    check(wcode[0] == 4'b0111, "R2 wake NOP", int'(wcode[0]), 7);
    // R3: order and encodings
    check(ln[0] == 7, "R3 command count", ln[0], 7);
    check(lcode[0][0] == 4'b0010 && laddr[0][0][10], "R3 precharge all 1", int'(lcode[0][0]), 2);
    check(lcode[0][1] == 4'b0000 && lba[0][1] == 2'b01, "R3 extended load", int'(lba[0][1]), 1);
    check(lcode[0][2] == 4'b0000 && lba[0][2] == 2'b00, "R3 base load", int'(lba[0][2]), 0);
    check(lcode[0][3] == 4'b0010 && laddr[0][3][10], "R3 precharge all 2", int'(lcode[0][3]), 2);
    check(lcode[0][4] == 4'b0001 && lcode[0][5] == 4'b0001, "R3 refresh pair",
          int'({lcode[0][4], lcode[0][5]}), 17);
    check(lcode[0][6] == 4'b0000 && lba[0][6] == 2'b00, "R3 clear load", int'(lcode[0][6]), 0);
    // R4: spacing
    check(lc[0][0] - fcke[0] == 1, "R4 first precharge", lc[0][0] - fcke[0], 1);
    check(lc[0][1] - lc[0][0] == T_RP + 1, "R4 after precharge", lc[0][1] - lc[0][0], T_RP + 1);
    check(lc[0][2] - lc[0][1] == T_MRD + 1, "R4 after ext load", lc[0][2] - lc[0][1], T_MRD + 1);
    check(lc[0][3] - lc[0][2] == T_MRD + 1, "R4 after base load", lc[0][3] - lc[0][2], T_MRD + 1);
    check(lc[0][4] - lc[0][3] == T_RP + 1, "R4 after precharge 2", lc[0][4] - lc[0][3], T_RP + 1);
    check(lc[0][5] - lc[0][4] == T_RFC + 1, "R4 after refresh", lc[0][5] - lc[0][4], T_RFC + 1);
    check(lc[0][6] - lc[0][5] == T_RFC + 1, "R4 after refresh 2", lc[0][6] - lc[0][5], T_RFC + 1);
    // R5: filler cycles
    check(viol[0] == 0, "R5 filler cycles", viol[0], 0);
    // R6 and R7: register contents
    check(laddr[0][1] == (ev & 13'h0002), "R6 extended value", int'(laddr[0][1]), int'(ev & 13'h0002));
    check(laddr[0][2] == (mv | 13'h0100), "R7 DLL reset load", int'(laddr[0][2]), int'(mv | 13'h0100));
    check(laddr[0][6] == (mv & ~13'h0100), "R7 DLL clear load", int'(laddr[0][6]), int'(mv & ~13'h0100));
    // R8: completion
    check(dcyc[0] - lc[0][6] == T_MRD + 1, "R8 done timing", dcyc[0] - lc[0][6], T_MRD + 1);
    // R9: read permission
    mr_cyc = lc[0][2];
    check(rcyc[0] - mr_cyc == T_DLL, "R9 read gap", rcyc[0] - mr_cyc, T_DLL);
    // R11: variant without the clear load
    check(ln[1] == 6, "R11 command count", ln[1], 6);
    check(lcode[1][5] == 4'b0001, "R11 last is refresh", int'(lcode[1][5]), 1);
    check(dcyc[1] - lc[1][5] == T_RFC + 1, "R11 done timing", dcyc[1] - lc[1][5], T_RFC + 1);
    check(viol[1] == 0, "R11 filler cycles", viol[1], 0);
    // R8: holds afterwards
    repeat (6) @(negedge clk);
    check(d0 && c0 && {s0, r0, a0, w0} == 4'b0111, "R8 done holds", int'({d0, c0}), 3);
  endtask

  // R10: restart mid-run and after completion
  task automatic t_restart();
    int s2;
    @(negedge clk); mode_val = 13'h0062; ext_mode = 13'h0002;
    pulse_start();
    repeat (T_PWR + 8) @(negedge clk);
    check(c0 == 1'b1, "R10 mid-run cke high", int'(c0), 1);
    pulse_start();
    @(negedge clk);
    check(c0 == 1'b0 && s0 == 1'b1, "R10 mid-run restart", int'({c0, s0}), 1);
    wait_finish();
    check(fcke[0] - s_cyc == T_PWR + 2, "R10 rerun wake", fcke[0] - s_cyc, T_PWR + 2);
    check(ln[0] == 7, "R10 rerun commands", ln[0], 7);
    @(negedge clk); start = 1'b1; s2 = cyc;
    @(negedge clk); start = 1'b0;
    check(d0 == 1'b1, "R10 done one cycle on", int'(d0), 1);
    @(negedge clk);
    check(cyc - s2 == 2, "R10 sample cycle", cyc - s2, 2);
    check(!d0 && !k0 && !c0 && s0, "R10 flags cleared", int'({d0, k0, c0}), 0);
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      pcke[i] = 1'b0; pdone[i] = 1'b0; pread[i] = 1'b0;
    end
    clear_logs();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full(13'h0062, 13'h1FFF);
    t_full(13'h0133, 13'h0000);
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule